// File: doc/BRIEF.md
# Polyphase FIR Decimator

This block lowers the sample rate of a signed fixed-point stream by an integer factor M. Its result is the same as running a lowpass FIR over every input and then keeping one result in M, but it never forms the results that would be thrown away. The prototype filter is split into M phase branches of TAPS/M taps each. Every accepted input sample is routed to one branch, and that branch's partial sum is added into a running total. When the group of M is complete, the total becomes the output.

Each input sample is qualified by `in_valid`. Cycles with `in_valid` low are idle. The output pulses `out_valid` once for every M accepted samples. The first pulse follows the very first sample after reset. The coefficients are a parameter array, so every product is formed with full precision and the accumulator is wide enough that it can never wrap.

An asynchronous active-low reset clears the sample history, the running total and the output. The block releases the reset in step with the clock.

Top module: `pfd_decimator`

## Requirements
- R1: While reset is held, and right after it, `out_valid` is 0 and `out_data` is 0.
- R2: Accepted samples are numbered from 0 after reset. `out_valid` is high for one cycle, in the cycle after each accepted sample whose number is a multiple of M (sample 0 gives the first pulse). It is high at no other time.
- R3: Output n equals the sum over j = 0..TAPS-1 of COEF[j] * x[M*n - j], computed exactly. COEF[0] multiplies the newest sample.
- R4: A cycle with `in_valid` low neither takes a sample nor changes any state. A stream that has idle cycles inserted gives the same outputs as the same stream sent without gaps.
- R5: `out_data` is a two's-complement value of DW+CW+clog2(TAPS) bits. It does not overflow, even when every input is at the most negative or most positive code.
- R6: Between pulses, `out_data` keeps the value of the last output.
- R7: Samples that would fall before sample 0 count as zero. A reset discards all earlier history, so the outputs after a reset are the zero-padded response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| in_valid | input | 1 | Marks `in_data` as a sample to take in this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle pulse for each decimated output |
| out_data | output | DW+CW+clog2(TAPS) | Signed full-precision output, held between pulses |

## Verification
An impulse on sample 0 brings out COEF[0], COEF[M], COEF[2M] and so on. An impulse on sample 1 brings out the taps of the other phase, COEF[M-1] first. Together they show that the phase-to-branch mapping and the coefficient order are right. A ramp and a pseudo-random stream exercise all branches together. The same kind of stream sent with idle gaps checks that those cycles are ignored. A reset in the middle of a run, followed by runs of the extreme codes, checks that history is cleared and that the accumulator has headroom.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // full-precision width of a sum of n products of dw x cw signed operands
  function automatic int unsigned sum_width(int unsigned dw, int unsigned cw, int unsigned n);
    return dw + cw + $clog2(n);
  endfunction
endpackage

// File: rtl/pfd_phase_ctr.sv
module pfd_phase_ctr #(
  parameter int unsigned M  = 4,
  localparam int unsigned BW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [BW-1:0] branch,
  output logic          grp_last
);
  logic [BW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (en) phase_d = (phase_q == BW'(M - 1)) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase_q <= '0;
    else if (en) phase_q <= phase_d;
  end

  // sample number t feeds branch (-t) mod M
  always_comb begin
    branch   = (phase_q == '0) ? '0 : BW'(M - 32'(phase_q));
    grp_last = (phase_q == '0);
  end
endmodule

// File: rtl/pfd_branch_hist.sv
module pfd_branch_hist #(
  parameter int unsigned M  = 4,
  parameter int unsigned L  = 4,
  parameter int unsigned DW = 16,
  localparam int unsigned BW = $clog2(M)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BW-1:0]        wr_branch,
  input  logic [DW-1:0]        wr_data,
  output logic [L-1:0][DW-1:0] taps
);
  logic [DW-1:0] hist_q [M][L-1];
  logic [DW-1:0] hist_d [M][L-1];

  always_comb begin
    hist_d = hist_q;
    for (int i = L - 2; i > 0; i--) hist_d[wr_branch][i] = hist_q[wr_branch][i-1];
    hist_d[wr_branch][0] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < M; k++)
        for (int i = 0; i < L - 1; i++) hist_q[k][i] <= '0;
    end else if (wr_en) begin
      hist_q <= hist_d;
    end
  end

  always_comb begin
    taps[0] = wr_data;
    for (int i = 1; i < L; i++) taps[i] = hist_q[wr_branch][i-1];
  end
endmodule

// File: rtl/pfd_branch_mac.sv
module pfd_branch_mac #(
  parameter int unsigned M  = 4,
  parameter int unsigned L  = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter logic signed [CW-1:0] COEF [M*L] = '{default: '0},
  localparam int unsigned BW = $clog2(M),
  localparam int unsigned PW = DW + CW,
  localparam int unsigned SW = pfd_pkg::sum_width(DW, CW, L)
) (
  input  logic [BW-1:0]         branch,
  input  logic [L-1:0][DW-1:0]  taps,
  output logic signed [SW-1:0]  partial
);
  logic signed [CW-1:0] coef_sel [L];
  logic signed [PW-1:0] prod     [L];

  for (genvar i = 0; i < L; i++) begin : g_tap
    always_comb begin
      coef_sel[i] = '0;
      for (int k = 0; k < M; k++)
        if (branch == BW'(k)) coef_sel[i] = COEF[k + M*i];
      prod[i] = $signed(taps[i]) * coef_sel[i];
    end
  end

  always_comb begin
    partial = '0;
    for (int i = 0; i < L; i++)
      partial = partial + $signed({{(SW-PW){prod[i][PW-1]}}, prod[i]});
  end
endmodule

// File: rtl/pfd_decimator.sv
module pfd_decimator #(
  parameter int unsigned M    = 4,
  parameter int unsigned TAPS = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter logic signed [CW-1:0] COEF [TAPS] = '{
    -16'sd32768, 16'sd120, -16'sd450, 16'sd1300, -16'sd3100, 16'sd9000, 16'sd24000, 16'sd32767,
    16'sd32767, 16'sd24000, 16'sd9000, -16'sd3100, 16'sd1300, -16'sd450, 16'sd120, -16'sd32768},
  localparam int unsigned L  = TAPS / M,
  localparam int unsigned BW = $clog2(M),
  localparam int unsigned SW = pfd_pkg::sum_width(DW, CW, L),
  localparam int unsigned AW = pfd_pkg::sum_width(DW, CW, TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_data
);
  // reset: asserts at once, releases after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [BW-1:0]        branch;
  logic                 grp_last;
  logic [L-1:0][DW-1:0] taps;
  logic signed [SW-1:0] partial;

  pfd_phase_ctr #(.M(M)) u_phase (
    .clk(clk), .rst_n(rst_core_n), .en(in_valid), .branch(branch), .grp_last(grp_last));

  pfd_branch_hist #(.M(M), .L(L), .DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_core_n), .wr_en(in_valid), .wr_branch(branch),
    .wr_data(in_data), .taps(taps));

  pfd_branch_mac #(.M(M), .L(L), .DW(DW), .CW(CW), .COEF(COEF)) u_mac (
    .branch(branch), .taps(taps), .partial(partial));

  logic signed [AW-1:0] acc_q, acc_d, sum_d;
  logic [AW-1:0]        y_q;
  logic                 vld_q, vld_d;

  always_comb begin
    sum_d = acc_q + $signed({{(AW-SW){partial[SW-1]}}, partial});
    vld_d = in_valid && grp_last;
    acc_d = grp_last ? '0 : sum_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_q <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) acc_q <= acc_d;
      if (vld_d)    y_q   <= sum_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = y_q;
endmodule

// File: rtl/pfd_decimator_chk.sv
module pfd_decimator_chk #(
  parameter int unsigned M  = 4,
  parameter int unsigned AW = 36,
  localparam int unsigned BW = $clog2(M)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [AW-1:0] out_data
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (in_valid) cnt_q <= (cnt_q == BW'(M - 1)) ? '0 : cnt_q + 1'b1;
  end

  AST_PULSE_AT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_q == '0) |=> out_valid); // R2
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && cnt_q == '0)); // R2
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !out_valid); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R6
endmodule

bind pfd_decimator pfd_decimator_chk #(.M(M), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/test_pfd_decimator.sv
`timescale 1ns/1ps
module test_pfd_decimator;
  localparam int M    = 4;
  localparam int TAPS = 16;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int AW   = DW + CW + $clog2(TAPS);
  localparam logic signed [CW-1:0] H [TAPS] = '{
    -16'sd32768, 16'sd120, -16'sd450, 16'sd1300, -16'sd3100, 16'sd9000, 16'sd24000, 16'sd32767,
    16'sd32767, 16'sd24000, 16'sd9000, -16'sd3100, 16'sd1300, -16'sd450, 16'sd120, -16'sd32768};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [AW-1:0] out_data;

  always #2 clk = ~clk;

  pfd_decimator #(.M(M), .TAPS(TAPS), .DW(DW), .CW(CW), .COEF(H)) i_pfd_decimator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  int     n_chk = 0;
  int     n_bad = 0;
  bit     in_reset = 1'b1;
  bit     finished = 1'b0;
  longint xs[$];
  longint exp_q[$];
  string  tag_q[$];
  longint last_out = 0;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one sample, push the expected output on group boundaries
  task automatic send(longint x, string tag);
    longint y;
    int t;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[DW-1:0];
    xs.push_back(x);
    t = xs.size() - 1;
    if (t % M == 0) begin
      y = 0;
      for (int j = 0; j < TAPS; j++)
        if (t - j >= 0) y += longint'(H[j]) * xs[t-j];
      exp_q.push_back(y);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hDEAD;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_reset = 1'b1;
    in_valid = 1'b0;
    rst_n    = 1'b0;
    xs.delete();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 out_data in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_data after reset", longint'(out_data), 0);
    last_out = 0;
    in_reset = 1'b0;
  endtask

  // monitor: scoreboard compare a little after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!in_reset) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected out_valid", 1, 0);
          end else begin
            string tg;
            longint e;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, longint'($signed(out_data)), e);
          end
          last_out = longint'($signed(out_data));
        end else begin
          check("R6 hold between pulses", longint'($signed(out_data)), last_out);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    longint lcg;
    do_reset();                                   // R1, R7
    // impulse on sample 0: COEF[0], COEF[M], ... (R3, R7)
    send(1, "R3 impulse at 0");
    for (int i = 0; i < 19; i++) send(0, "R3 impulse at 0");
    // impulse on sample 1 of a group: other phase taps
    send(0, "R3 impulse at 1");
    send(1, "R3 impulse at 1");
    for (int i = 0; i < 18; i++) send(0, "R3 impulse at 1");
    // ramp
    for (int i = 0; i < 32; i++) send(longint'(i * 997 - 15000), "R3 ramp");
    // pseudo-random with idle gaps
    lcg = 12345;
    for (int i = 0; i < 64; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 64'h7FFFFFFF;
      send(((lcg >> 8) & 16'hFFFF) - 32768, "R4 gapped stream");
      if (i % 3 == 1) idle(1 + i % 4);
    end
    idle(8);
    check("R2 all outputs seen", longint'(exp_q.size()), 0);
    // reset with nonzero history, then extremes
    do_reset();                                   // R7 history cleared
    for (int i = 0; i < 32; i++) send(-32768, "R5 most negative");
    for (int i = 0; i < 32; i++) send((i % 2 == 0) ? 32767 : -32768, "R5 alternating extremes");
    for (int i = 0; i < 16; i++) send(32767, "R5 most positive");
    idle(8);
    check("R2 all outputs seen", longint'(exp_q.size()), 0);
    finish_run();
  end
endmodule